// File: doc/BRIEF.md
# Page-Relative Address and Branch Unit

This block sits beside the decoder of a small 16-bit processor and works out, in a single cycle of combinational logic, every address that an instruction needs. Page-relative operations form their address by keeping the upper seven bits of the current program counter and putting the 9-bit instruction field in the low bits. Operations that load, store or take the address of a page location all use this path. Indexed operations add an unsigned 6-bit offset to a base register value. The block also sign-extends the 5-bit immediate operand of the register-immediate arithmetic forms.

The block holds a three-bit condition state: negative, zero and positive. It is rewritten from any 16-bit result that the datapath strobes in. A conditional branch compares its three mask bits against that state. If the branch is taken, the next program counter is the page address. Otherwise the program counter advances by one.

The decoder supplies a 3-bit operation code. Memory access and register writeback are left to the surrounding datapath. The memory-request output only tells that datapath whether the effective address is meant for memory.

Top module: `pgaddr_branch_unit`

## Requirements
- R1: For op codes LOAD_PAGE (1), STORE_PAGE (2), ADDR_PAGE (3) and BRANCH (6), the page address is (pc_i AND 0xFE00) OR instr_i[8:0]. For the first three of these, ea_o equals the page address.
- R2: mem_req_o is 1 for LOAD_PAGE, STORE_PAGE, LOAD_IDX (4) and STORE_IDX (5). It is 0 for ADDR_PAGE, BRANCH, NOP (0) and IMM (7).
- R3: For LOAD_IDX and STORE_IDX, ea_o equals base_i plus the zero-extended instr_i[5:0], taken modulo 2^16.
- R4: When result_vld_i is high at a rising edge, flags_o = {N,Z,P} becomes 3'b100 if result_i[15] is 1, 3'b010 if result_i is zero, and 3'b001 otherwise. The new value is visible after that edge. Exactly one flag is set at all times.
- R5: When result_vld_i is low at a rising edge, flags_o keeps its value, whatever result_i holds.
- R6: Reset leaves flags_o = 3'b010, with only the zero flag set.
- R7: For BRANCH, taken_o is 1 when any of instr_i[11] (N), instr_i[10] (Z) or instr_i[9] (P) is 1 together with the matching flag. A mask of 3'b111 is always taken.
- R8: For BRANCH with mask instr_i[11:9] = 3'b000, the branch is never taken.
- R9: next_pc_o equals the page address when taken_o is 1. Otherwise it equals pc_i + 1, wrapping at 16 bits. taken_o is 0 for every op code other than BRANCH.
- R10: imm_o is instr_i[4:0] sign-extended to 16 bits, for every op code.
- R11: A branch in the same cycle as a flag update is decided from the flags held before that update.
- R12: For NOP and IMM, ea_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Decoded operation code |
| pc_i | input | 16 | Current program counter |
| instr_i | input | 16 | Instruction word |
| base_i | input | 16 | Base register value for indexed operations |
| result_i | input | 16 | Result value used to set the flags |
| result_vld_i | input | 1 | Strobe: the flags take result_i at this edge |
| ea_o | output | 16 | Effective address |
| mem_req_o | output | 1 | Effective address is meant for memory |
| next_pc_o | output | 16 | Next program counter |
| taken_o | output | 1 | Branch taken |
| imm_o | output | 16 | Sign-extended 5-bit immediate |
| flags_o | output | 3 | Held flags {N,Z,P} |

## Verification
A flag update and a conditional branch can fall in the same cycle: the datapath strobes in a result while the next instruction is a branch. The bench first loads the flags with a negative result. It then presents, in one cycle, a zero result with the strobe high and a branch whose mask selects only zero. In that cycle the branch must be judged not taken, with next_pc_o at pc_i + 1. In the following cycle, with the strobe low and the same branch still presented, the branch must be taken and flags_o must read zero.

// File: rtl/pab_pkg.sv
package pab_pkg;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_LOAD_PAGE  = 3'd1,
    OP_STORE_PAGE = 3'd2,
    OP_ADDR_PAGE  = 3'd3,
    OP_LOAD_IDX   = 3'd4,
    OP_STORE_IDX  = 3'd5,
    OP_BRANCH     = 3'd6,
    OP_IMM        = 3'd7
  } pab_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } pab_flags_t;

  localparam pab_flags_t FLAGS_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

endpackage

// File: rtl/pab_flags.sv
module pab_flags
  import pab_pkg::*;
#(
  parameter int unsigned XLEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] result_i,
  input  logic            result_vld_i,
  output pab_flags_t      flags_q,
  output logic            upd_evt
);

  function automatic pab_flags_t classify(input logic [XLEN-1:0] v);
    pab_flags_t f;
    f.n = v[XLEN-1];
    f.z = (v == '0);
    f.p = !v[XLEN-1] && (v != '0);
    return f;
  endfunction

  pab_flags_t flags_d;

  assign upd_evt = result_vld_i;

  always_comb begin
    flags_d = flags_q;
    if (upd_evt) flags_d = classify(result_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= FLAGS_RESET;
    else        flags_q <= flags_d;
  end

endmodule

// File: rtl/pab_addr_gen.sv
module pab_addr_gen
  import pab_pkg::*;
#(
  parameter int unsigned XLEN      = 16,
  parameter int unsigned PAGE_BITS = 9,
  parameter int unsigned IDX_BITS  = 6
) (
  input  pab_op_e         op_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] base_i,
  output logic [XLEN-1:0] page_addr_o,
  output logic [XLEN-1:0] ea_o,
  output logic            mem_req_o,
  output logic            page_sel_o,
  output logic            idx_sel_o
);

  localparam logic [XLEN-1:0] PAGE_MASK = {{(XLEN-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

  function automatic logic [XLEN-1:0] splice_page(input logic [XLEN-1:0] pc,
                                                   input logic [XLEN-1:0] ins);
    logic [XLEN-1:0] fld;
    fld = {{(XLEN-PAGE_BITS){1'b0}}, ins[PAGE_BITS-1:0]};
    return (pc & PAGE_MASK) | fld;
  endfunction

  function automatic logic [XLEN-1:0] index_addr(input logic [XLEN-1:0] base,
                                                  input logic [XLEN-1:0] ins);
    logic [XLEN-1:0] off;
    off = {{(XLEN-IDX_BITS){1'b0}}, ins[IDX_BITS-1:0]};
    return base + off;
  endfunction

  assign page_addr_o = splice_page(pc_i, instr_i);
  assign page_sel_o  = (op_i == OP_LOAD_PAGE) || (op_i == OP_STORE_PAGE) ||
                       (op_i == OP_ADDR_PAGE);
  assign idx_sel_o   = (op_i == OP_LOAD_IDX) || (op_i == OP_STORE_IDX);

  always_comb begin
    ea_o      = '0;
    mem_req_o = 1'b0;
    unique case (op_i)
      OP_LOAD_PAGE, OP_STORE_PAGE: begin
        ea_o      = page_addr_o;
        mem_req_o = 1'b1;
      end
      OP_ADDR_PAGE, OP_BRANCH: begin
        ea_o      = page_addr_o;
      end
      OP_LOAD_IDX, OP_STORE_IDX: begin
        ea_o      = index_addr(base_i, instr_i);
        mem_req_o = 1'b1;
      end
      default: begin
        ea_o      = '0;
        mem_req_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pab_branch.sv
module pab_branch
  import pab_pkg::*;
#(
  parameter int unsigned XLEN      = 16,
  parameter int unsigned PAGE_BITS = 9
) (
  input  pab_op_e         op_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  pab_flags_t      flags_i,
  input  logic [XLEN-1:0] page_addr_i,
  output logic            taken_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [2:0]      cond_mask_o
);

  localparam int unsigned MASK_LSB = PAGE_BITS;

  function automatic logic resolve(input logic [2:0] mask, input pab_flags_t f);
    return |(mask & {f.n, f.z, f.p});
  endfunction

  function automatic logic [XLEN-1:0] step(input logic [XLEN-1:0] pc);
    return pc + {{(XLEN-1){1'b0}}, 1'b1};
  endfunction

  assign cond_mask_o = instr_i[MASK_LSB+2:MASK_LSB];
  assign taken_o     = (op_i == OP_BRANCH) && resolve(cond_mask_o, flags_i);
  assign next_pc_o   = taken_o ? page_addr_i : step(pc_i);

endmodule

// File: rtl/pgaddr_branch_unit.sv
module pgaddr_branch_unit
  import pab_pkg::*;
#(
  parameter int unsigned XLEN      = 16,
  parameter int unsigned PAGE_BITS = 9,
  parameter int unsigned IDX_BITS  = 6,
  parameter int unsigned IMM_BITS  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] result_i,
  input  logic            result_vld_i,
  output logic [XLEN-1:0] ea_o,
  output logic            mem_req_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic [XLEN-1:0] imm_o,
  output logic [2:0]      flags_o
);

  function automatic logic [XLEN-1:0] sext_imm(input logic [XLEN-1:0] ins);
    return {{(XLEN-IMM_BITS){ins[IMM_BITS-1]}}, ins[IMM_BITS-1:0]};
  endfunction

  pab_op_e         op;
  pab_flags_t      flags_q;
  logic            upd_evt;
  logic [XLEN-1:0] page_addr;
  logic            page_sel;
  logic            idx_sel;
  logic [2:0]      cond_mask;

  assign op = pab_op_e'(op_i);

  pab_flags #(.XLEN(XLEN)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .result_i     (result_i),
    .result_vld_i (result_vld_i),
    .flags_q      (flags_q),
    .upd_evt      (upd_evt)
  );

  pab_addr_gen #(.XLEN(XLEN), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS)) u_addr (
    .op_i        (op),
    .pc_i        (pc_i),
    .instr_i     (instr_i),
    .base_i      (base_i),
    .page_addr_o (page_addr),
    .ea_o        (ea_o),
    .mem_req_o   (mem_req_o),
    .page_sel_o  (page_sel),
    .idx_sel_o   (idx_sel)
  );

  pab_branch #(.XLEN(XLEN), .PAGE_BITS(PAGE_BITS)) u_br (
    .op_i        (op),
    .pc_i        (pc_i),
    .instr_i     (instr_i),
    .flags_i     (flags_q),
    .page_addr_i (page_addr),
    .taken_o     (taken_o),
    .next_pc_o   (next_pc_o),
    .cond_mask_o (cond_mask)
  );

  assign imm_o   = sext_imm(instr_i);
  assign flags_o = flags_q;

endmodule

// File: rtl/pab_checker.sv
module pab_checker #(
  parameter int unsigned XLEN = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] result_i,
  input logic            result_vld_i,
  input logic [XLEN-1:0] ea_o,
  input logic            mem_req_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic [2:0]      flags_o,
  input logic [2:0]      cond_mask,
  input logic [XLEN-1:0] page_addr
);

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags_o) == 1); // R4

  AST_FLAGS_ZERO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (result_vld_i && result_i == '0) |=> (flags_o == 3'b010)); // R4

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_vld_i |=> $stable(flags_o)); // R5

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd6 && cond_mask == 3'b111) |-> taken_o); // R7

  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_mask == 3'b000) |-> !taken_o); // R8

  AST_NON_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != 3'd6) |-> !taken_o); // R9

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (next_pc_o == page_addr)); // R9

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !taken_o |-> (next_pc_o == pc_i + {{(XLEN-1){1'b0}}, 1'b1})); // R9

  AST_ADDR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 || op_i == 3'd6) |-> !mem_req_o); // R2

  AST_IDLE_EA: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 || op_i == 3'd7) |-> (ea_o == '0 && !mem_req_o)); // R12

endmodule

bind pgaddr_branch_unit pab_checker #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_i         (op_i),
  .pc_i         (pc_i),
  .result_i     (result_i),
  .result_vld_i (result_vld_i),
  .ea_o         (ea_o),
  .mem_req_o    (mem_req_o),
  .next_pc_o    (next_pc_o),
  .taken_o      (taken_o),
  .flags_o      (flags_o),
  .cond_mask    (cond_mask),
  .page_addr    (page_addr)
);

// File: tb/sim_pgaddr_branch_unit.sv
module sim_pgaddr_branch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [15:0] pc_i = '0, instr_i = '0, base_i = '0, result_i = '0;
  logic        result_vld_i = 1'b0;
  logic [15:0] ea_o, next_pc_o, imm_o;
  logic        mem_req_o, taken_o;
  logic [2:0]  flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgaddr_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .pc_i(pc_i), .instr_i(instr_i),
    .base_i(base_i), .result_i(result_i), .result_vld_i(result_vld_i),
    .ea_o(ea_o), .mem_req_o(mem_req_o), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .imm_o(imm_o), .flags_o(flags_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (op %0d pc %h instr %h)",
               req, act, exp, op_i, pc_i, instr_i);
    end
  endtask

  task automatic put_flags(input logic [15:0] v);
    @(negedge clk);
    result_i = v; result_vld_i = 1'b1;
    @(negedge clk);
    result_vld_i = 1'b0;
    #1;
  endtask

  function automatic logic [2:0] exp_flags(input logic [15:0] v);
    if ($signed(v) < 0) return 3'b100;
    if (v == 16'd0)     return 3'b010;
    return 3'b001;
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] pcs [5];
    logic [15:0] page;
    logic [2:0]  fl;
    pcs[0] = 16'h0000; pcs[1] = 16'h1234; pcs[2] = 16'hFFFF;
    pcs[3] = 16'hFE00; pcs[4] = 16'h81FF;

    repeat (3) @(posedge clk);
    #1;
    chk("R6 reset flags", {13'd0, flags_o}, 16'h0002);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R6 flags after release", {13'd0, flags_o}, 16'h0002);

    // R1 R2 R9 page addressing sweep, flags still zero-only
    for (int p = 0; p < 5; p++) begin
      for (int f = 0; f < 512; f++) begin
        pc_i = pcs[p];
        page = (pcs[p] & 16'hFE00) | 16'(f);
        for (int o = 1; o <= 3; o++) begin
          op_i = 3'(o);
          instr_i = {4'hA, 3'b111, 9'(f)};
          #1;
          chk("R1 page ea", ea_o, page);
          chk("R2 mem_req", {15'd0, mem_req_o}, (o == 3) ? 16'd0 : 16'd1);
          chk("R9 non-branch next_pc", next_pc_o, pcs[p] + 16'd1);
        end
        op_i = 3'd6;
        instr_i = {4'h0, 3'b010, 9'(f)};
        #1;
        chk("R7 branch taken on Z", {15'd0, taken_o}, 16'd1);
        chk("R9 taken target", next_pc_o, page);
        chk("R2 branch no req", {15'd0, mem_req_o}, 16'd0);
      end
    end

    // R3 indexed sweep
    op_i = 3'd4;
    for (int b = 0; b < 6; b++) begin
      base_i = (b == 5) ? 16'hFFF0 : 16'(b * 16'h3137);
      for (int k = 0; k < 64; k++) begin
        for (int s = 0; s < 2; s++) begin
          op_i = s ? 3'd5 : 3'd4;
          instr_i = {10'h3FF, 6'(k)};
          #1;
          chk("R3 indexed ea", ea_o, base_i + 16'(k));
          chk("R2 indexed req", {15'd0, mem_req_o}, 16'd1);
        end
      end
    end

    // R10 immediate sweep, R12 idle ops
    for (int i = 0; i < 32; i++) begin
      op_i = (i % 2) ? 3'd7 : 3'd0;
      instr_i = {11'h5A5, 5'(i)};
      #1;
      chk("R10 sign-extended imm", imm_o, (i >= 16) ? 16'(i - 32) : 16'(i));
      chk("R12 idle ea", ea_o, 16'd0);
      chk("R2 idle req", {15'd0, mem_req_o}, 16'd0);
    end

    // R4 R7 R8 branch masks against each flag state
    for (int v = 0; v < 5; v++) begin
      logic [15:0] rv;
      case (v)
        0: rv = 16'h8000; 1: rv = 16'h0000; 2: rv = 16'h7FFF;
        3: rv = 16'hFFFF; default: rv = 16'h0001;
      endcase
      put_flags(rv);
      fl = exp_flags(rv);
      chk("R4 flags from result", {13'd0, flags_o}, {13'd0, fl});
      pc_i = 16'h4321;
      op_i = 3'd6;
      for (int m = 0; m < 8; m++) begin
        instr_i = {4'h0, 3'(m), 9'h0AB};
        #1;
        chk((m == 0) ? "R8 empty mask" : "R7 mask vs flags",
            {15'd0, taken_o}, {15'd0, |(3'(m) & fl)});
        chk("R9 branch next_pc", next_pc_o,
            (|(3'(m) & fl)) ? 16'h42AB : 16'h4322);
      end
    end

    // R5 hold with strobe low
    put_flags(16'h0005);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      result_i = 16'(c * 16'h4001 + 16'h8000);
      #1;
      chk("R5 flags hold", {13'd0, flags_o}, 16'h0001);
    end
    op_i = 3'd6; instr_i = {4'h0, 3'b001, 9'h000};
    #1;
    chk("R5 held P drives branch", {15'd0, taken_o}, 16'd1);

    // R11 same-cycle update and branch
    put_flags(16'h9000);
    @(negedge clk);
    pc_i = 16'h0200; op_i = 3'd6; instr_i = {4'h0, 3'b010, 9'h033};
    result_i = 16'h0000; result_vld_i = 1'b1;
    #1;
    chk("R11 old flags decide", {15'd0, taken_o}, 16'd0);
    chk("R11 fallthrough", next_pc_o, 16'h0201);
    @(negedge clk);
    result_vld_i = 1'b0;
    #1;
    chk("R11 flags now zero", {13'd0, flags_o}, 16'h0002);
    chk("R11 taken next cycle", {15'd0, taken_o}, 16'd1);
    chk("R11 target", next_pc_o, 16'h0233);

    // R9 wrap of the increment
    op_i = 3'd0; pc_i = 16'hFFFF;
    #1;
    chk("R9 pc wrap", next_pc_o, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule